// File: doc/BRIEF.md
# Two-Bit Global History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register with the outcomes of the most recently resolved branches. The value of that register picks one of several pattern tables. Within the chosen table, a slice of the branch address picks a two-bit saturating counter, and the upper bit of that counter is the guess. With the default settings there are four tables of 1024 counters each. That is the same storage as a single 4096-entry table, but the counters are split by recent branch behaviour, so two branches that depend on each other can be learned.

Fetch sends a lookup with its program counter. One cycle later the block returns the guess, together with the history value it used. The pipeline carries that history value along with the branch. When the branch resolves, the update port receives the branch address, the real outcome and the history value that came back with the guess. The counter is trained in the table the guess was read from, even if the history register has moved on since then. At the same time, the outcome is shifted into the history register.

After a reset, the block walks through every counter index and writes the weakly-not-taken value into all tables. It raises `ready` when that walk is complete.

Top module: `ghp_predictor`

## Requirements
- R1: A lookup sampled with `lkp_valid` high at a clock edge produces `pred_valid` high after the next edge. `pred_valid` is low after a cycle with no lookup.
- R2: `pred_hist` returns the history value held at the lookup edge, and that value is the table number read. History bit 1 holds the newest outcome and bit 0 the one before it, with taken = 1. So 00 means both not taken, 01 means the older was taken and the newer not taken, 10 means the older was not taken and the newer taken, and 11 means both taken.
- R3: The history register changes only on an accepted update. The new bit 1 becomes `upd_taken` and the new bit 0 becomes the old bit 1.
- R4: The counter index is PC bits [PC_LSB+IDX_W-1 : PC_LSB]. PC bits outside that field have no effect on the entry chosen.
- R5: An accepted update changes only one counter: the entry at the update index in table `upd_hist`, whatever the current history is.
- R6: Each counter saturates in the range 0 to 3. It increments on a taken outcome and decrements on a not-taken outcome. `pred_taken` is 1 exactly when the counter read is 2 or 3.
- R7: Once initialisation completes after reset, every counter holds 1 and the history holds 00.
- R8: `ready` stays low for exactly 2**IDX_W cycles after reset is released, then stays high. While `ready` is low, `pred_taken` is 0, and any update is dropped with no change to the history or to the counters.
- R9: An update sampled at edge t is seen by lookups sampled at edge t+2 or later. A lookup at edge t+1 still reads the old counter. Back-to-back updates to the same entry accumulate with none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_pc | input | PC_W | Fetch address for the lookup |
| pred_valid | output | 1 | Prediction available |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History value that selected the table |
| upd_valid | input | 1 | Resolved branch update |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | HIST_W | History value returned with that branch's prediction |
| ready | output | 1 | Initialisation walk complete |

## Verification
The bench builds the block with IDX_W = 6 and PC_W = 16, and keeps the default two history bits. With 64 entries per table, the initialisation walk is short enough to measure exactly. A small pool of branch addresses also collides often, so random traffic keeps hitting saturation at both ends, entries shared between addresses that differ only in ignored bits, and back-to-back updates that need the write forwarding. Updates that carry a history value different from the current register exercise training of a table other than the one currently in use.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

  localparam int CTR_W = 2;

  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_INIT = ctr_t'(1);
  localparam ctr_t CTR_MAX  = ctr_t'(3);
  localparam ctr_t CTR_MIN  = ctr_t'(0);

  // saturating step toward the observed direction
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_MAX) ? cur : cur + ctr_t'(1);
    else       res = (cur == CTR_MIN) ? cur : cur - ctr_t'(1);
    return res;
  endfunction

endpackage

// File: rtl/ghp_bank.sv
// One pattern table: read-first storage with a lookup read port, an
// update read port and a single write port.
module ghp_bank
  import ghp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] lk_idx,
  output ctr_t             lk_data,
  input  logic [IDX_W-1:0] up_idx,
  output ctr_t             up_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_data
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    lk_data <= mem[lk_idx];
    up_data <= mem[up_idx];
  end

endmodule

// File: rtl/ghp_history.sv
// Global outcome history: newest outcome enters at the top bit.
module ghp_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);

  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {outcome, hist[HIST_W-1:1]};
  end

  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist[HIST_W-1] == $past(outcome)); // R3
  AST_HIST_OLDER: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist[HIST_W-2:0] == $past(hist[HIST_W-1:1])); // R3
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist)); // R3

endmodule

// File: rtl/ghp_writer.sv
// Owns the write port of all tables: the post-reset fill walk, then the
// two-cycle read-modify-write of resolved branches with forwarding.
module ghp_writer
  import ghp_pkg::*;
#(
  parameter int HIST_W = 2,
  parameter int IDX_W  = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        upd_valid,
  input  logic [HIST_W-1:0]           upd_tbl,
  input  logic [IDX_W-1:0]            upd_idx,
  input  logic                        upd_taken,
  input  logic [(1<<HIST_W)-1:0][CTR_W-1:0] rd_data,
  output logic [(1<<HIST_W)-1:0]      wr_en,
  output logic [IDX_W-1:0]            wr_idx,
  output ctr_t                        wr_data,
  output logic                        ready
);

  localparam int NTBL = 1 << HIST_W;

  logic [IDX_W-1:0]  fill_idx;
  logic              accept;
  logic              s_vld;
  logic [HIST_W-1:0] s_tbl;
  logic [IDX_W-1:0]  s_idx;
  logic              s_tk;
  logic              fwd_hit;
  ctr_t              fwd_val;
  ctr_t              cur;
  ctr_t              nxt;

  assign accept = upd_valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready    <= 1'b0;
      fill_idx <= '0;
      s_vld    <= 1'b0;
      s_tbl    <= '0;
      s_idx    <= '0;
      s_tk     <= 1'b0;
      fwd_hit  <= 1'b0;
      fwd_val  <= CTR_INIT;
    end else begin
      if (!ready) begin
        fill_idx <= fill_idx + 1'b1;
        if (fill_idx == {IDX_W{1'b1}}) ready <= 1'b1;
      end
      s_vld   <= accept;
      s_tbl   <= upd_tbl;
      s_idx   <= upd_idx;
      s_tk    <= upd_taken;
      // the entry read this cycle is being written this same edge
      fwd_hit <= accept && s_vld && (s_tbl == upd_tbl) && (s_idx == upd_idx);
      fwd_val <= nxt;
    end
  end

  assign cur = fwd_hit ? fwd_val : ctr_t'(rd_data[s_tbl]);
  assign nxt = ctr_step(cur, s_tk);

  always_comb begin
    wr_en   = '0;
    wr_idx  = s_idx;
    wr_data = nxt;
    if (!ready) begin
      wr_en   = '1;
      wr_idx  = fill_idx;
      wr_data = CTR_INIT;
    end else if (s_vld) begin
      wr_en[s_tbl] = 1'b1;
    end
  end

  AST_ONE_TABLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    ready |-> $onehot0(wr_en)); // R5
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (ready && s_vld) |-> ((s_tk && (wr_data == cur + ctr_t'(1) || wr_data == CTR_MAX)) ||
                          (!s_tk && (wr_data == cur - ctr_t'(1) || wr_data == CTR_MIN)))); // R6
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
    (ready && s_vld && s_tk && cur == CTR_MAX) |-> wr_data == CTR_MAX); // R6
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R8
  AST_INIT_NO_TRAIN: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !s_vld); // R8

  initial begin
    if (NTBL != (1 << HIST_W)) $error("table count mismatch");
  end

endmodule

// File: rtl/ghp_predictor.sv
module ghp_predictor
  import ghp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkp_valid,
  input  logic [PC_W-1:0]   lkp_pc,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist,
  output logic              ready
);

  localparam int NTBL = 1 << HIST_W;

  logic [IDX_W-1:0]            lk_idx;
  logic [IDX_W-1:0]            up_idx;
  logic [HIST_W-1:0]           hist;
  logic [NTBL-1:0][CTR_W-1:0]  rd_lk;
  logic [NTBL-1:0][CTR_W-1:0]  rd_up;
  logic [NTBL-1:0]             wr_en;
  logic [IDX_W-1:0]            wr_idx;
  ctr_t                        wr_data;
  logic                        rdy_q;
  logic                        unused_pc_bits;

  assign lk_idx = lkp_pc[PC_LSB +: IDX_W];
  assign up_idx = upd_pc[PC_LSB +: IDX_W];
  assign unused_pc_bits = ^{lkp_pc, upd_pc};

  ghp_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_valid && ready),
    .outcome  (upd_taken),
    .hist     (hist)
  );

  ghp_writer #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_writer (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .upd_tbl   (upd_hist),
    .upd_idx   (up_idx),
    .upd_taken (upd_taken),
    .rd_data   (rd_up),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .ready     (ready)
  );

  for (genvar g = 0; g < NTBL; g++) begin : g_tbl
    ghp_bank #(.IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .lk_idx  (lk_idx),
      .lk_data (rd_lk[g]),
      .up_idx  (up_idx),
      .up_data (rd_up[g]),
      .wr_en   (wr_en[g]),
      .wr_idx  (wr_idx),
      .wr_data (wr_data)
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_hist  <= '0;
      rdy_q      <= 1'b0;
    end else begin
      pred_valid <= lkp_valid;
      pred_hist  <= hist;
      rdy_q      <= ready;
    end
  end

  // upper counter bit of the table picked by the captured history
  assign pred_taken = pred_valid && rdy_q && rd_lk[pred_hist][CTR_W-1];

  AST_PRED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> pred_valid); // R1
  AST_PRED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lkp_valid |=> !pred_valid && !pred_taken); // R1
  AST_PRED_HIST: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> pred_hist == $past(hist)); // R2
  AST_QUIET_IN_INIT: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !pred_taken); // R8
  AST_HIST_FROZEN_IN_INIT: assert property (@(posedge clk) disable iff (rst)
    !ready |=> $stable(hist)); // R8

endmodule

// File: tb/tb_ghp_predictor.sv
module tb_ghp_predictor;

  localparam int PCW  = 16;
  localparam int LSB  = 2;
  localparam int IDXW = 6;
  localparam int HW   = 2;
  localparam int NT   = 1 << HW;
  localparam int DEP  = 1 << IDXW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lkp_valid = 1'b0;
  logic [PCW-1:0] lkp_pc = '0;
  logic pred_valid, pred_taken;
  logic [HW-1:0] pred_hist;
  logic upd_valid = 1'b0;
  logic [PCW-1:0] upd_pc = '0;
  logic upd_taken = 1'b0;
  logic [HW-1:0] upd_hist = '0;
  logic ready;

  always #10 clk = ~clk;

  ghp_predictor #(.PC_W(PCW), .PC_LSB(LSB), .IDX_W(IDXW), .HIST_W(HW)) dut (
    .clk(clk), .rst(rst),
    .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist),
    .ready(ready)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_ctr [NT][DEP];
  logic [HW-1:0] m_hist;
  bit pend_v;
  int pend_t, pend_i, pend_val;

  function automatic int idx_of(input logic [PCW-1:0] pc);
    return int'((pc >> LSB) & (DEP - 1));
  endfunction

  function automatic int step(input int c, input bit tk);
    if (tk) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // one clock: drive at negedge, predict with the model, check after the edge
  task automatic cycle(input bit lv, input logic [PCW-1:0] lpc, input bit uv,
                       input logic [PCW-1:0] upc, input bit utk,
                       input logic [HW-1:0] uh, input string req);
    bit rdy, e_tk;
    logic [HW-1:0] e_h;
    @(negedge clk);
    lkp_valid = lv; lkp_pc = lpc;
    upd_valid = uv; upd_pc = upc; upd_taken = utk; upd_hist = uh;
    rdy  = ready;
    e_tk = rdy && (m_ctr[m_hist][idx_of(lpc)] >= 2);
    e_h  = m_hist;
    if (pend_v) m_ctr[pend_t][pend_i] = pend_val;
    pend_v = 0;
    if (uv && rdy) begin
      pend_v   = 1;
      pend_t   = int'(uh);
      pend_i   = idx_of(upc);
      pend_val = step(m_ctr[pend_t][pend_i], utk);
      m_hist   = {utk, m_hist[HW-1:1]};
    end
    @(posedge clk);
    #1;
    if (lv) begin
      check(pred_valid == 1'b1, {req, "/R1 valid"}, int'(pred_valid), 1);
      check(pred_taken == e_tk, {req, " taken"}, int'(pred_taken), int'(e_tk));
      check(pred_hist == e_h, {req, "/R2 hist"}, int'(pred_hist), int'(e_h));
    end else begin
      check(pred_valid == 1'b0, {req, "/R1 idle"}, int'(pred_valid), 0);
    end
  endtask

  task automatic idle();
    cycle(0, '0, 0, '0, 0, '0, "idle");
  endtask

  task automatic look(input logic [PCW-1:0] pc, input string req);
    cycle(1, pc, 0, '0, 0, '0, req);
  endtask

  task automatic train(input logic [PCW-1:0] pc, input bit tk, input logic [HW-1:0] uh,
                       input string req);
    cycle(0, '0, 1, pc, tk, uh, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    logic [PCW-1:0] pool [8];
    logic [PCW-1:0] pa, pb;
    void'($urandom(32'h1c0ffee));
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < DEP; i++) m_ctr[t][i] = 1;
    m_hist = '0;
    pend_v = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(ready == 1'b0, "R8 ready low after reset", int'(ready), 0);

    // updates and lookups during the fill walk must have no effect
    for (int k = 0; k < 6; k++)
      cycle(1, PCW'(k * 4), 1, PCW'(k * 4), 1'b1, 2'b11, "R8 init");
    n = 7;
    while (!ready && n < 4 * DEP) begin
      @(posedge clk); #1;
      n++;
    end
    check(n == DEP, "R8 fill cycles", n, DEP);

    // reset state: every entry weakly not taken, history 00
    for (int i = 0; i < DEP; i += 7) look(PCW'(i << LSB), "R7 reset state");
    check(m_hist == 2'b00, "R7 model hist", int'(m_hist), 0);

    pa = 16'h0124;
    pb = 16'h0040;
    // build history 11 so table 3 is in use
    train(pb, 1, m_hist, "R3 prime");
    train(pb, 1, m_hist, "R3 prime");
    look(pa, "R2 table 3 before training");
    train(pa, 1, 2'b11, "R6 inc");
    look(pa, "R9 one cycle after update sees old");
    look(pa, "R9 two cycles after update sees new");
    // back-to-back updates on one entry: forwarding path
    train(pa, 1, 2'b11, "R9 b2b");
    train(pa, 1, 2'b11, "R9 b2b");
    train(pa, 1, 2'b11, "R6 saturate top");
    idle();
    look(pa, "R6 saturated taken");
    // address bits outside the index field are ignored
    look(pa ^ PCW'(1 << (LSB + IDXW)), "R4 alias high bits");
    look(pa ^ PCW'(1), "R4 alias low bits");
    // train another table while history is 11: current table unaffected
    train(pb, 1, 2'b00, "R5 other table");
    train(pb, 1, 2'b00, "R5 other table");
    idle();
    look(pb, "R5 current table untouched");
    // walk a counter down to zero and past it
    for (int k = 0; k < 5; k++) train(pa, 0, 2'b11, "R6 saturate bottom");
    idle();
    train(pb, 1, m_hist, "R3 restore");
    train(pb, 1, m_hist, "R3 restore");
    idle();
    look(pa, "R6 bottom not taken");
    train(pa, 1, 2'b11, "R6 from zero");
    idle();
    look(pa, "R6 one step from zero");

    // random traffic over a colliding address pool
    for (int k = 0; k < 8; k++) pool[k] = PCW'($urandom_range(0, DEP - 1) << LSB);
    for (int k = 0; k < 4000; k++) begin
      logic [PCW-1:0] lp, up;
      logic [HW-1:0] uh;
      bit lv, uv, tk;
      lp = pool[$urandom_range(0, 7)] | PCW'($urandom_range(0, 3) << (LSB + IDXW));
      up = pool[$urandom_range(0, 7)] | PCW'($urandom_range(0, 3));
      lv = ($urandom_range(0, 3) != 0);
      uv = ($urandom_range(0, 1) != 0);
      tk = ($urandom_range(0, 9) < 6);
      uh = ($urandom_range(0, 9) < 7) ? m_hist : HW'($urandom_range(0, NT - 1));
      cycle(lv, lp, uv, up, tk, uh, "R5 R6 R9 random");
    end
    idle();
    check(ready == 1'b1, "R8 ready stays high", int'(ready), 1);
    finish_run();
  end

endmodule